// File: doc/BRIEF.md
# Ethernet Multicast Hash Address Filter

This block makes the receive-side decision on whether a frame is addressed to this station. The six destination address bytes of an incoming frame arrive one per cycle on `rx_byte`, qualified by `rx_valid`. The first byte is also marked with `rx_first`. One cycle after the sixth byte has been taken, the block raises `done` for a single cycle. In that same cycle `accept` gives the verdict.

A destination whose first byte has bit 0 clear is an individual address. It is accepted only when all six bytes equal the programmed station address. A destination with that bit set is a group address. It is hashed with a bit-reflected CRC-32, and the six most significant bits of the CRC register select one bit of a 64-bit filter. That filter is organised as four 16-bit words. The broadcast address is a group address like any other, so it gets no special treatment. When promiscuous mode is on, every completed address is accepted.

The controller has three states. `ST_IDLE` waits for a marked first byte. `ST_COLLECT` takes the remaining bytes. `ST_DECIDE` presents the verdict for one cycle. The transitions are:
- `ST_IDLE` to `ST_COLLECT` on a marked first byte.
- `ST_COLLECT` to `ST_DECIDE` on the sixth byte.
- `ST_COLLECT` back to itself, restarting the count, when a new marked first byte arrives.
- `ST_DECIDE` to `ST_COLLECT` when a marked first byte arrives in that cycle.
- `ST_DECIDE` to `ST_IDLE` otherwise.

Top module: `mcast_addr_filter`

## Requirements
- R1: After reset `done` and `accept` are both 0 and the block waits in `ST_IDLE`.
- R2: A byte is taken only in a cycle with `rx_valid` high. Cycles with `rx_valid` low between address bytes neither advance nor disturb the frame.
- R3: `done` is high in exactly the one cycle that follows the clock edge at which the sixth byte was taken.
- R4: `accept` is 0 in every cycle in which `done` is 0.
- R5: The address is a group address exactly when bit 0 of the first received byte is 1.
- R6: An individual address is accepted only when received byte k (k = 0 for the first byte) equals `station_addr[8k+7:8k]` for all six k.
- R7: The hash register is preset to all ones. It takes each byte least significant bit first, using the reflected polynomial 0xEDB88320, with no final inversion. The hash index is register bits 31:26.
- R8: Index bits 5:4 select filter word w, which is `filter_bits[16w+15:16w]`. Index bits 3:0 select the bit within that word. A group address is accepted when that bit is 1.
- R9: With all four filter words at 0xFFFF, every group address is accepted.
- R10: The all-ones broadcast address is accepted only when its own hash bit is set or promiscuous mode is on.
- R11: With `promisc` high, every completed address is accepted, whether it is individual or group.
- R12: A byte with `rx_valid` high and `rx_first` low is ignored in `ST_IDLE`. A marked first byte arriving in the middle of a frame discards the partial frame and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Address byte present this cycle |
| rx_first | input | 1 | Marks the first address byte of a frame |
| rx_byte | input | 8 | Address byte, received order |
| station_addr | input | 48 | Station address, byte k at bits 8k+7:8k |
| filter_bits | input | 64 | Group filter, word w at bits 16w+15:16w |
| promisc | input | 1 | Promiscuous mode enable |
| done | output | 1 | One-cycle pulse: verdict valid |
| accept | output | 1 | Frame accepted (meaningful with `done`) |

## Verification
A corrupted hash register or byte counter shows up in the very next verdict. A bad count moves or drops the `done` pulse, so the verdict arrives before or after the cycle that follows the sixth byte. A wrong hash bit selects a different filter bit, which is exposed by filters with exactly one bit set or exactly one bit cleared. A stale match or group flag carried over from an aborted or earlier frame flips `accept` on the first frame that follows. The restart and gap scenarios are there to expose that case.

// File: rtl/mf_pkg.sv
package mf_pkg;
    localparam int BYTE_W = 8;
    localparam int CRC_W  = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_DECIDE
    } mf_state_e;
endpackage

// File: rtl/mf_crc_step.sv
// One byte of a bit-reflected CRC, least significant data bit first.
module mf_crc_step
    import mf_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c  = crc_in;
        fb = 1'b0;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[0] ^ data[i];
            c  = c >> 1;
            if (fb) c = c ^ POLY;
        end
        crc_out = c;
    end
endmodule

// File: rtl/mf_hash_lookup.sv
// Picks one filter bit: upper index bits select the word, lower bits the bit.
module mf_hash_lookup #(
    parameter int WORD_W     = 16,
    parameter int FILT_WORDS = 4,
    localparam int IDX_W     = $clog2(FILT_WORDS * WORD_W),
    localparam int SEL_W     = $clog2(FILT_WORDS),
    localparam int BIT_W     = $clog2(WORD_W)
) (
    input  logic [IDX_W-1:0]             hash_idx,
    input  logic [FILT_WORDS*WORD_W-1:0] filter_bits,
    output logic                         hit
);
    logic [WORD_W-1:0] words [FILT_WORDS];

    for (genvar g = 0; g < FILT_WORDS; g++) begin : g_word
        assign words[g] = filter_bits[g*WORD_W +: WORD_W];
    end

    logic [SEL_W-1:0] word_sel;
    logic [BIT_W-1:0] bit_sel;

    assign word_sel = hash_idx[IDX_W-1 -: SEL_W];
    assign bit_sel  = hash_idx[BIT_W-1:0];
    assign hit      = words[word_sel][bit_sel];
endmodule

// File: rtl/mf_station_cmp.sv
// Compares one received byte against the matching station address byte.
module mf_station_cmp
    import mf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic [CNT_W-1:0]             byte_idx,
    input  logic [BYTE_W-1:0]            data,
    input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
    output logic                         eq
);
    logic [BYTE_W-1:0] sbytes [ADDR_BYTES];

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
        assign sbytes[g] = station_addr[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        eq = 1'b0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (int'(byte_idx) == k) eq = (data == sbytes[k]);
        end
    end
endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter
    import mf_pkg::*;
#(
    parameter int               ADDR_BYTES = 6,
    parameter int               WORD_W     = 16,
    parameter int               FILT_WORDS = 4,
    parameter logic [CRC_W-1:0] POLY       = 32'hEDB88320,
    localparam int              CNT_W      = $clog2(ADDR_BYTES + 1),
    localparam int              IDX_W      = $clog2(FILT_WORDS * WORD_W),
    localparam int              ADDR_W     = ADDR_BYTES * BYTE_W,
    localparam int              FILT_W     = FILT_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [FILT_W-1:0] filter_bits,
    input  logic              promisc,
    output logic              done,
    output logic              accept
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    mf_state_e        state, state_n;
    logic [CRC_W-1:0] crc_q, crc_seed, crc_next;
    logic [CNT_W-1:0] cnt_q, cmp_idx;
    logic             group_q, match_q;
    logic             take, start, byte_eq, hash_hit;

    // A marked first byte always starts a frame; other bytes count only mid-frame.
    assign start    = rx_valid && rx_first;
    assign take     = start || (rx_valid && state == ST_COLLECT);
    assign crc_seed = start ? '1 : crc_q;
    assign cmp_idx  = start ? '0 : cnt_q;

    mf_crc_step #(.POLY(POLY)) u_crc (
        .crc_in  (crc_seed),
        .data    (rx_byte),
        .crc_out (crc_next)
    );

    mf_station_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
        .byte_idx     (cmp_idx),
        .data         (rx_byte),
        .station_addr (station_addr),
        .eq           (byte_eq)
    );

    mf_hash_lookup #(.WORD_W(WORD_W), .FILT_WORDS(FILT_WORDS)) u_hash (
        .hash_idx    (crc_q[CRC_W-1 -: IDX_W]),
        .filter_bits (filter_bits),
        .hit         (hash_hit)
    );

    // Next-state decode
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (start) state_n = ST_COLLECT;
            ST_COLLECT: if (!start && rx_valid && cnt_q == LAST_IDX)
                            state_n = ST_DECIDE;
            ST_DECIDE:  state_n = start ? ST_COLLECT : ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // State register and frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            crc_q   <= '1;
            cnt_q   <= '0;
            group_q <= 1'b0;
            match_q <= 1'b0;
        end else begin
            state <= state_n;
            if (take) begin
                crc_q   <= crc_next;
                cnt_q   <= cmp_idx + CNT_W'(1);
                group_q <= start ? rx_byte[0] : group_q;
                match_q <= (start ? 1'b1 : match_q) && byte_eq;
            end
        end
    end

    // Outputs
    always_comb begin
        done   = (state == ST_DECIDE);
        accept = done && (promisc || (group_q ? hash_hit : match_q));
    end
endmodule

// File: rtl/mf_filter_checker.sv
module mf_filter_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic promisc,
    input logic done,
    input logic accept
);
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rx_valid));

    a_r4_accept_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !accept);

    a_r11_prom_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (done && promisc) |-> accept);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!done && !accept));
endmodule

bind mcast_addr_filter mf_filter_checker u_mf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .promisc  (promisc),
    .done     (done),
    .accept   (accept)
);

// File: tb/mcast_addr_filter_tb_top.sv
`timescale 1ns/1ps
module mcast_addr_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_first = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [47:0] station_addr = '0;
    logic [63:0] filter_bits = '0;
    logic        promisc = 1'b0;
    logic        done, accept;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [47:0] STATION = 48'h5544_3322_1100;   // bytes 00,11,22,33,44,55
    localparam logic [47:0] MC_A    = 48'hFB00_005E_0001;   // 01,00,5E,00,00,FB
    localparam logic [47:0] MC_B    = 48'h0100_0000_C233;   // 33,C2,00,00,00,01 (odd first byte)
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

    always #5 clk = ~clk;

    mcast_addr_filter dut_i (
        .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_first (rx_first),
        .rx_byte (rx_byte), .station_addr (station_addr), .filter_bits (filter_bits),
        .promisc (promisc), .done (done), .accept (accept)
    );

    // Reflected CRC-32 index, computed from the requirement text (R7)
    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic x;
                x = c[0] ^ a[8*k + b];
                c = {1'b0, c[31:1]} ^ (x ? 32'hEDB88320 : 32'h0);
            end
        end
        return c[31:26];
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {done,accept} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Sends an address; gap inserts an idle cycle after each of the first five bytes.
    task automatic send(input string req, input logic [47:0] a, input bit gap, input logic exp_acc);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_first = (k == 0); rx_byte = a[8*k +: 8];
            if (gap && k < 5) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_first = 1'b0;
                chk({req, " R2 gap"}, {done, accept}, 2'b00);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_first = 1'b0;
        chk(req, {done, accept}, {1'b1, exp_acc});
        @(negedge clk);
        chk({req, " R3 pulse end"}, {done, accept}, 2'b00);
    endtask

    task automatic t_reset();
        chk("R1 reset", {done, accept}, 2'b00);
    endtask

    task automatic t_unicast();
        station_addr = STATION; filter_bits = '1; promisc = 1'b0;
        send("R6 station match", STATION, 1'b0, 1'b1);
        send("R6 last byte differs", STATION ^ 48'h0100_0000_0000, 1'b0, 1'b0);
        send("R6 first byte differs", STATION ^ 48'h0000_0000_0002, 1'b0, 1'b0);
        send("R2 R6 match with gaps", STATION, 1'b1, 1'b1);
    endtask

    task automatic t_group();
        logic [5:0] ia = hidx(MC_A);
        station_addr = MC_A & ~48'h1;   // differs from MC_A only in the group bit
        filter_bits = 64'h1 << ia;
        send("R8 own hash bit set", MC_A, 1'b0, 1'b1);
        filter_bits = ~(64'h1 << ia);
        send("R8 own hash bit clear", MC_A, 1'b0, 1'b0);
        filter_bits = 64'h1 << ia;
        send("R5 individual ignores filter", MC_A & ~48'h1, 1'b0, 1'b1);
        filter_bits = 64'h1 << hidx(MC_B);
        send("R7 other group index", MC_B, 1'b1, 1'b1);
        send("R7 index distinct", MC_A, 1'b0, (hidx(MC_A) == hidx(MC_B)));
    endtask

    task automatic t_all_ones();
        filter_bits = '1; station_addr = STATION;
        send("R9 all ones group A", MC_A, 1'b0, 1'b1);
        send("R9 all ones group B", MC_B, 1'b0, 1'b1);
    endtask

    task automatic t_bcast();
        logic [5:0] ib = hidx(BCAST);
        filter_bits = 64'h1 << ib;
        send("R10 broadcast bit set", BCAST, 1'b0, 1'b1);
        filter_bits = ~(64'h1 << ib);
        send("R10 broadcast bit clear", BCAST, 1'b0, 1'b0);
        filter_bits = '0; promisc = 1'b1;
        send("R10 broadcast promiscuous", BCAST, 1'b0, 1'b1);
        promisc = 1'b0;
    endtask

    task automatic t_promisc();
        filter_bits = '0; station_addr = STATION; promisc = 1'b1;
        send("R11 promiscuous unicast", ~STATION & ~48'h1, 1'b0, 1'b1);
        send("R11 promiscuous group", MC_A, 1'b1, 1'b1);
        promisc = 1'b0;
        send("R11 promiscuous off", ~STATION & ~48'h1, 1'b0, 1'b0);
    endtask

    task automatic t_restart();
        station_addr = STATION; filter_bits = '0; promisc = 1'b0;
        // Unmarked bytes in idle must not start a frame
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_first = 1'b0; rx_byte = STATION[8*(k%6) +: 8];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R12 unmarked bytes ignored", {done, accept}, 2'b00);
        // Partial group frame of three bytes, then a full station frame
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_first = (k == 0); rx_byte = MC_A[8*k +: 8];
        end
        send("R12 restart mid-frame", STATION, 1'b0, 1'b1);
        // Restart after five bytes: a sixth-byte slot reused by a new first byte
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_first = (k == 0); rx_byte = STATION[8*k +: 8];
        end
        send("R12 restart after five bytes", MC_A, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {done, accept}, 2'b00);
        t_unicast();
        t_group();
        t_all_ones();
        t_bcast();
        t_promisc();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule